// File: doc/BRIEF.md
# Host/Processor Doorbell and Interrupt Register Bank

This block is a byte-wide register bank that carries interrupt requests in both directions between an external host port and an embedded processor port. The host rings doorbells toward the processor by writing ones. The processor acknowledges a doorbell by writing ones to clear it. In the other direction, device event pulses and semaphore-grant pulses latch pending bits toward the host. The host acknowledges those by writing ones to them.

Each pending bit is gated by a host-writable enable bit. The gated bits are reduced to one host interrupt line. That line is driven by a two-state machine, so it comes straight from a flop. The states are `IRQ_QUIET` (line low) and `IRQ_RAISED` (line high). The transition `RAISE` goes from `IRQ_QUIET` to `IRQ_RAISED` when any enabled pending bit is set. The transition `DROP` goes from `IRQ_RAISED` to `IRQ_QUIET` when none is set. Otherwise the machine holds its state.

A sticky flag records that a watchdog reset happened. Only the power-on reset clears it. Host reads are combinational from the registers. The processor port always presents the doorbell register.

Top module: `hdb_doorbell_regs`

## Requirements
- R1: After power-on reset (`rst_n` low), every register reads 0, `host_irq` is 0 and `proc_irq` is 0.
- R2: A host write to address 0x0F sets each doorbell bit whose data bit is 1 at the next clock edge. A data bit of 0 leaves that doorbell bit as it is. A host read of 0x0F and `proc_rdata` return the doorbell bits.
- R3: A processor write (`proc_wr`) clears each doorbell bit whose `proc_wdata` bit is 1, and leaves bits written 0 alone. `proc_irq` is 1 whenever any doorbell bit is 1.
- R4: A pulse on `dev_evt[i]` sets bit i of the register at address 0x13. A host write of 1 to a bit there clears it, and a write of 0 leaves it unchanged.
- R5: A pulse on `sem_grant[k]` (k = 0, 1, 2) sets bit k of the register at address 0x14. Bits 2:0 there are cleared by a host write of 1, and bits 7:3 always read 0.
- R6: Enable bits for the device sources are read/write at address 0x10, bits 7:0. Enable bits for the semaphore sources are read/write at address 0x11, bits 2:0, and bits 7:3 there read 0. All enable bits reset to 0.
- R7: `host_irq` equals, one clock after, the OR over all 11 pending bits of (pending AND enable).
- R8: When a set event and a clear reach the same bit in the same cycle, the bit ends up 1.
- R9: Bit 0 at address 0x0E is set by a `wdog_evt` pulse and stays set until power-on reset. Host writes to 0x0E have no effect. Bits 7:1 there, and every unmapped address, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| host_addr | input | 8 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| host_irq | output | 1 | Registered interrupt toward the host |
| proc_wr | input | 1 | Processor doorbell clear strobe |
| proc_wdata | input | 8 | Processor clear mask, one bit per doorbell |
| proc_rdata | output | 8 | Current doorbell bits |
| proc_irq | output | 1 | OR of the doorbell bits |
| dev_evt | input | 8 | Device event pulses toward the host |
| sem_grant | input | 3 | Semaphore-grant pulses for semaphores 0 to 2 |
| wdog_evt | input | 1 | Pulse marking a watchdog reset |

## Verification
A pending or doorbell bit that is wrong inside the bank shows on the next read of its address, through the combinational read mux. For doorbells it also shows at once on `proc_rdata` and `proc_irq`. A wrong enable or pending bit reaches `host_irq` exactly one clock later, because the interrupt state machine adds one flop. The bench compares every read, both interrupt outputs and the doorbell view in every cycle against a model. A lost event, a missed clear, or a wrong set/clear priority is therefore caught within one or two cycles of the stimulus.

// File: rtl/hdb_pkg.sv
package hdb_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int NUM_DEV = 8;
    localparam int NUM_SEM = 3;
    localparam int NUM_SRC = NUM_DEV + NUM_SEM;

    localparam logic [ADDR_W-1:0] OFS_WDOG = 8'h0E;
    localparam logic [ADDR_W-1:0] OFS_BELL = 8'h0F;
    localparam logic [ADDR_W-1:0] OFS_ENLO = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ENHI = 8'h11;
    localparam logic [ADDR_W-1:0] OFS_PLO  = 8'h13;
    localparam logic [ADDR_W-1:0] OFS_PHI  = 8'h14;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/hdb_w1c_bank.sv
module hdb_w1c_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] bits_o
);
    logic [W-1:0] bits_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bits_q[i] <= 1'b0;
            else if (set_i[i])
                bits_q[i] <= 1'b1;
            else if (clr_i[i])
                bits_q[i] <= 1'b0;
        end
    end

    assign bits_o = bits_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((bits_q & $past(set_i)) == $past(set_i))); // R8

    AST_CLEAR_ONLY_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((~bits_q & $past(bits_q & ~clr_i)) == '0)); // R4
endmodule

// File: rtl/hdb_irq_fsm.sv
module hdb_irq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic irq_o
);
    import hdb_pkg::*;

    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IRQ_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        irq_o   = 1'b0;
        unique case (state_q)
            IRQ_QUIET: begin
                irq_o = 1'b0;
                if (req_i) state_d = IRQ_RAISED;
            end
            IRQ_RAISED: begin
                irq_o = 1'b1;
                if (!req_i) state_d = IRQ_QUIET;
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    AST_IRQ_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_o == $past(req_i))); // R7
endmodule

// File: rtl/hdb_doorbell_regs.sv
module hdb_doorbell_regs (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [hdb_pkg::ADDR_W-1:0]  host_addr,
    input  logic                        host_wr,
    input  logic [hdb_pkg::DATA_W-1:0]  host_wdata,
    output logic [hdb_pkg::DATA_W-1:0]  host_rdata,
    output logic                        host_irq,
    input  logic                        proc_wr,
    input  logic [hdb_pkg::DATA_W-1:0]  proc_wdata,
    output logic [hdb_pkg::DATA_W-1:0]  proc_rdata,
    output logic                        proc_irq,
    input  logic [hdb_pkg::NUM_DEV-1:0] dev_evt,
    input  logic [hdb_pkg::NUM_SEM-1:0] sem_grant,
    input  logic                        wdog_evt
);
    import hdb_pkg::*;

    localparam int PAD_W = DATA_W - NUM_SEM;

    logic [DATA_W-1:0]  bell_set, bell_clr, bell_q;
    logic [NUM_SRC-1:0] pend_set, pend_clr, pend_q;
    logic [NUM_SRC-1:0] en_q;
    logic               wdog_q;
    logic               any_req;

    logic hit_bell, hit_enlo, hit_enhi, hit_plo, hit_phi;
    assign hit_bell = host_wr && (host_addr == OFS_BELL);
    assign hit_enlo = host_wr && (host_addr == OFS_ENLO);
    assign hit_enhi = host_wr && (host_addr == OFS_ENHI);
    assign hit_plo  = host_wr && (host_addr == OFS_PLO);
    assign hit_phi  = host_wr && (host_addr == OFS_PHI);

    // Doorbells: host sets, processor clears.
    assign bell_set = hit_bell ? host_wdata : '0;
    assign bell_clr = proc_wr  ? proc_wdata : '0;

    hdb_w1c_bank #(.W(DATA_W)) u_bell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (bell_set),
        .clr_i (bell_clr),
        .bits_o(bell_q)
    );

    // Pending toward host: device events low, semaphore grants high.
    assign pend_set = {sem_grant, dev_evt};
    assign pend_clr = {(hit_phi ? host_wdata[NUM_SEM-1:0] : {NUM_SEM{1'b0}}),
                       (hit_plo ? host_wdata[NUM_DEV-1:0] : {NUM_DEV{1'b0}})};

    hdb_w1c_bank #(.W(NUM_SRC)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (pend_set),
        .clr_i (pend_clr),
        .bits_o(pend_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            if (hit_enlo) en_q[NUM_DEV-1:0]       <= host_wdata[NUM_DEV-1:0];
            if (hit_enhi) en_q[NUM_SRC-1:NUM_DEV] <= host_wdata[NUM_SEM-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wdog_q <= 1'b0;
        else if (wdog_evt)
            wdog_q <= 1'b1;
    end

    assign any_req = |(pend_q & en_q);

    hdb_irq_fsm u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (any_req),
        .irq_o (host_irq)
    );

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_WDOG: host_rdata = {{(DATA_W-1){1'b0}}, wdog_q};
            OFS_BELL: host_rdata = bell_q;
            OFS_ENLO: host_rdata = en_q[NUM_DEV-1:0];
            OFS_ENHI: host_rdata = {{PAD_W{1'b0}}, en_q[NUM_SRC-1:NUM_DEV]};
            OFS_PLO:  host_rdata = pend_q[NUM_DEV-1:0];
            OFS_PHI:  host_rdata = {{PAD_W{1'b0}}, pend_q[NUM_SRC-1:NUM_DEV]};
            default:  host_rdata = '0;
        endcase
    end

    assign proc_rdata = bell_q;
    assign proc_irq   = |bell_q;

    AST_WDOG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_q |=> wdog_q); // R9

    AST_GRANT_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == OFS_PHI) |-> (host_rdata[DATA_W-1:NUM_SEM] == '0)); // R5

    AST_HOST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> ($past(en_q) != '0)); // R7

    AST_DOORBELL_HOST_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit_bell |=> ((bell_q & $past(host_wdata)) == $past(host_wdata))); // R2
endmodule

// File: tb/sim_hdb_doorbell_regs.sv
`timescale 1ns/1ps
module sim_hdb_doorbell_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_irq;
    logic       proc_wr = 1'b0;
    logic [7:0] proc_wdata = '0;
    logic [7:0] proc_rdata;
    logic       proc_irq;
    logic [7:0] dev_evt = '0;
    logic [2:0] sem_grant = '0;
    logic       wdog_evt = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state
    logic [7:0]  m_bell = '0;
    logic [10:0] m_pend = '0;
    logic [10:0] m_en = '0;
    logic        m_wdog = 1'b0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    hdb_doorbell_regs u0 (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_irq(host_irq),
        .proc_wr(proc_wr), .proc_wdata(proc_wdata),
        .proc_rdata(proc_rdata), .proc_irq(proc_irq),
        .dev_evt(dev_evt), .sem_grant(sem_grant), .wdog_evt(wdog_evt)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'h0E:   return {7'b0, m_wdog};
            8'h0F:   return m_bell;
            8'h10:   return m_en[7:0];
            8'h11:   return {5'b0, m_en[10:8]};
            8'h13:   return m_pend[7:0];
            8'h14:   return {5'b0, m_pend[10:8]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        case (a)
            8'h0E:   return "R9";
            8'h0F:   return "R2";
            8'h10:   return "R6";
            8'h11:   return "R6";
            8'h13:   return "R4";
            8'h14:   return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [7:0] a, input logic w, input logic [7:0] d,
                        input logic pw, input logic [7:0] pd,
                        input logic [7:0] de, input logic [2:0] sg, input logic wd,
                        input string tag);
        string t;
        @(negedge clk);
        host_addr = a; host_wr = w; host_wdata = d;
        proc_wr = pw; proc_wdata = pd;
        dev_evt = de; sem_grant = sg; wdog_evt = wd;
        #1;
        t = (tag != "") ? tag : req_of(a);
        chk(host_rdata == exp_read(a), t, host_rdata, exp_read(a));
        chk(host_irq == m_irq, (tag != "") ? tag : "R7", {7'b0, host_irq}, {7'b0, m_irq});
        chk(proc_rdata == m_bell, (tag != "") ? tag : "R2", proc_rdata, m_bell);
        chk(proc_irq == (|m_bell), (tag != "") ? tag : "R3", {7'b0, proc_irq}, {7'b0, |m_bell});
        @(posedge clk);
        #1;
        m_irq  = |(m_pend & m_en);
        m_bell = (m_bell & ~(pw ? pd : 8'h00)) | ((w && a == 8'h0F) ? d : 8'h00);
        m_pend[7:0]  = (m_pend[7:0]  & ~((w && a == 8'h13) ? d : 8'h00)) | de;
        m_pend[10:8] = (m_pend[10:8] & ~((w && a == 8'h14) ? d[2:0] : 3'b0)) | sg;
        if (w && a == 8'h10) m_en[7:0]  = d;
        if (w && a == 8'h11) m_en[10:8] = d[2:0];
        m_wdog = m_wdog | wd;
    endtask

    task automatic idle_read(input logic [7:0] a, input string tag);
        step(a, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 3'b0, 1'b0, tag);
    endtask

    logic [7:0] addr_pool [0:8];

    initial begin
        void'($urandom(32'd12345));
        addr_pool[0] = 8'h0E; addr_pool[1] = 8'h0F; addr_pool[2] = 8'h10;
        addr_pool[3] = 8'h11; addr_pool[4] = 8'h12; addr_pool[5] = 8'h13;
        addr_pool[6] = 8'h14; addr_pool[7] = 8'h15; addr_pool[8] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state across the map
        for (int i = 0; i < 9; i++) idle_read(addr_pool[i], "R1");

        // R2/R3: doorbell set by host, write 0 keeps, processor clears
        step(8'h0F, 1, 8'hA5, 0, 8'h00, 8'h00, 3'b0, 0, "R2");
        step(8'h0F, 1, 8'h00, 0, 8'h00, 8'h00, 3'b0, 0, "R2");
        idle_read(8'h0F, "R2");
        step(8'h0F, 0, 8'h00, 1, 8'h05, 8'h00, 3'b0, 0, "R3");
        idle_read(8'h0F, "R3");
        step(8'h0F, 0, 8'h00, 1, 8'hFF, 8'h00, 3'b0, 0, "R3");
        idle_read(8'h0F, "R3");

        // R4/R5/R6/R7: events, enables, interrupt
        step(8'h10, 1, 8'h81, 0, 8'h00, 8'h01, 3'b100, 0, "R6");
        step(8'h11, 1, 8'hFC, 0, 8'h00, 8'h00, 3'b0, 0, "R6");
        idle_read(8'h11, "R6");
        idle_read(8'h14, "R5");
        step(8'h13, 1, 8'h00, 0, 8'h00, 8'h00, 3'b0, 0, "R4");
        step(8'h13, 1, 8'h01, 0, 8'h00, 8'h00, 3'b0, 0, "R4");
        step(8'h14, 1, 8'hFF, 0, 8'h00, 8'h00, 3'b0, 0, "R5");
        idle_read(8'h14, "R5");
        idle_read(8'h13, "R7");
        idle_read(8'h13, "R7");

        // R8: set and clear in the same cycle
        step(8'h13, 1, 8'h02, 0, 8'h00, 8'h02, 3'b0, 0, "R8");
        idle_read(8'h13, "R8");
        step(8'h0F, 1, 8'h10, 1, 8'h10, 8'h00, 3'b0, 0, "R8");
        idle_read(8'h0F, "R8");

        // R9: watchdog flag sticky, writes ignored
        step(8'h0E, 0, 8'h00, 0, 8'h00, 8'h00, 3'b0, 1, "R9");
        step(8'h0E, 1, 8'hFF, 0, 8'h00, 8'h00, 3'b0, 0, "R9");
        idle_read(8'h0E, "R9");
        step(8'h0E, 1, 8'h00, 0, 8'h00, 8'h00, 3'b0, 0, "R9");
        idle_read(8'h0E, "R9");

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            a = ($urandom % 8 == 7) ? 8'($urandom) : addr_pool[$urandom % 8];
            step(a, 1'($urandom % 2), 8'($urandom),
                 1'($urandom % 4 == 0), 8'($urandom & $urandom),
                 8'($urandom & $urandom & $urandom), 3'($urandom & $urandom),
                 1'($urandom % 500 == 0), "");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule